// File: doc/BRIEF.md
# Split-Half Alternating Read Sequencer

This block drives a synchronous RAM through a three-step test used to find how closely spaced reads can be before data comes back wrong. It writes all-zero words into the lower half of the array and all-one words into the upper half. It then reads every word back in address order and checks each one. Last, it issues reads that ping-pong between address k of the lower half and address k of the upper half. Because each read returns the complement of the read before it, every access forces the data lines through a full swing.

The spacing of the ping-pong reads comes from the `interval` input, counted in clock cycles. An outside agent lowers `interval` from one run to the next. The smallest interval that still ends without a failure is the access-time limit. Holding one fast interval over many runs gives a running-time check. The sequencer keeps the first failing address and the step it failed in. It raises `done` when the run is over.

Top module: `alt_access_tester`

## Requirements
- R1: A `start` seen while idle begins a fill. The fill lasts N = 2^ADDR_W cycles, starting in the cycle after the start edge. Cycle i writes address i (`mem_we`=1). The data is all zeros when the top address bit is 0 and all ones when it is 1.
- R2: A verify pass follows the fill with no gap. It takes N cycles, reads addresses 0 to N-1 in order (one per cycle), and keeps `mem_we` low.
- R3: The alternating pass follows the verify pass with no gap. Its reads run in the order 0, N/2, 1, N/2+1, and so on, ending at N/2-1 and then N-1. No writes occur during this pass.
- R4: Each alternating read address is held for exactly `interval` cycles. An `interval` of 0 acts as 1.
- R5: Data read from the address presented in cycle c is taken from `mem_rdata` in cycle c+1. A word that differs from the expected value raises `fail`. The expected value is all zeros for addresses with top bit 0 and all ones for addresses with top bit 1. A run with no mismatch ends with `fail` low.
- R6: `fail_addr` holds the address of the first mismatch of a run, and `fail_alt` holds the pass it occurred in (0 = verify, 1 = alternating). Later mismatches in the same run change neither output, and `fail` stays high.
- R7: `done` and `fail` clear on the start edge. `done` rises 2N + N*max(interval,1) + 2 cycles after the start edge, is low before that, and stays high until the next start.
- R8: A `start` pulse during a run has no effect on the access sequence or on when `done` rises.
- R9: After reset, `done`, `fail` and `mem_we` are 0 and `mem_addr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run (accepted only while idle) |
| interval | input | IVL_W | Cycles between alternating reads (0 acts as 1) |
| mem_addr | output | ADDR_W | RAM address |
| mem_we | output | 1 | RAM write enable |
| mem_wdata | output | DATA_W | RAM write data |
| mem_rdata | input | DATA_W | RAM read data, one cycle after the address |
| done | output | 1 | Run finished |
| fail | output | 1 | At least one mismatch in this run |
| fail_addr | output | ADDR_W | Address of the first mismatch |
| fail_alt | output | 1 | Pass of the first mismatch (0 verify, 1 alternating) |

## Verification
All outputs are registered, so the access pattern expected for cycle j after the start edge is compared in cycle j itself, sampled on the falling edge. Cycle j counts from 0 in the cycle after the edge that accepted `start`. A read presented in cycle c is captured by the bench RAM at the next edge and judged one edge after that. The bench therefore judges `fail`, `fail_addr` and `fail_alt` only in the cycle where `done` is due, cycle 2N + N*I + 2, by which time every judgement has landed. The bench checks `done` to be low one cycle earlier and high in that exact cycle. Faults are made active from an exact cycle: from the start, or from cycle 2N for faults meant to appear only in the alternating pass. This makes the phase of the first failure known in advance.

// File: rtl/aat_pkg.sv
`timescale 1ns/1ps
package aat_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FILL,
    ST_VERIFY,
    ST_ALT,
    ST_DRAIN1,
    ST_DRAIN2
  } aat_state_t;
endpackage

// File: rtl/aat_pacer.sv
`timescale 1ns/1ps
// Down-counter that spaces alternating reads by a programmable number of cycles.
module aat_pacer #(
  parameter int IVL_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [IVL_W-1:0] interval,
  output logic             expire
);
  logic [IVL_W-1:0] cnt;
  logic [IVL_W-1:0] eff;

  assign eff    = (interval == '0) ? IVL_W'(1) : interval;
  assign expire = (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= eff - 1'b1;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  AST_PACE_RELOAD: assert property (@(posedge clk) disable iff (rst)
    (!load && !expire) |=> !$past(load) && (cnt < $past(cnt))) // R4
    else $error("pacer did not count down");
endmodule

// File: rtl/aat_checker.sv
`timescale 1ns/1ps
// Aligns each read with its returning data, compares against the split-half
// expectation and latches the first mismatch.
module aat_checker #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              rd_v,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_alt,
  input  logic [DATA_W-1:0] rdata,
  output logic              fail,
  output logic [ADDR_W-1:0] fail_addr,
  output logic              fail_alt
);
  logic              st_v;
  logic [ADDR_W-1:0] st_addr;
  logic              st_alt;
  logic [DATA_W-1:0] expect_word;
  logic              mismatch;

  assign expect_word = {DATA_W{st_addr[ADDR_W-1]}};
  assign mismatch    = st_v && (rdata != expect_word);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      st_v      <= 1'b0;
      st_addr   <= '0;
      st_alt    <= 1'b0;
      fail      <= 1'b0;
      fail_addr <= '0;
      fail_alt  <= 1'b0;
    end else begin
      st_v    <= rd_v;
      st_addr <= rd_addr;
      st_alt  <= rd_alt;
      if (mismatch && !fail) begin
        fail      <= 1'b1;
        fail_addr <= st_addr;
        fail_alt  <= st_alt;
      end
    end
  end

  AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (rst)
    (fail && !clear) |=> fail && $stable(fail_addr) && $stable(fail_alt)) // R6
    else $error("first failure record changed");

  AST_FAIL_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(fail) |-> $past(rd_v, 2)) // R5
    else $error("fail raised without a read two cycles earlier");
endmodule

// File: rtl/alt_access_tester.sv
`timescale 1ns/1ps
// Split-half fill, in-order verify, then paced ping-pong reads between halves.
// ADDR_W must be at least 2.
module alt_access_tester
  import aat_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8,
  parameter int IVL_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [IVL_W-1:0]  interval,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              done,
  output logic              fail,
  output logic [ADDR_W-1:0] fail_addr,
  output logic              fail_alt
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int HW    = ADDR_W - 1;
  localparam logic [ADDR_W-1:0] LAST  = ADDR_W'(DEPTH - 1);
  localparam logic [HW-1:0]     HLAST = HW'((DEPTH / 2) - 1);

  aat_state_t        state;
  logic [ADDR_W-1:0] idx;
  logic [ADDR_W-1:0] idx_nxt;
  logic [HW-1:0]     half_nxt;
  logic              side;
  logic              rd_v;
  logic              rd_alt;
  logic              go;
  logic              pace_load;
  logic              pace_expire;
  logic              alt_final;

  assign go        = (state == ST_IDLE) && start;
  assign idx_nxt   = idx + 1'b1;
  assign half_nxt  = idx[HW-1:0] + 1'b1;
  assign alt_final = side && (idx[HW-1:0] == HLAST);
  assign pace_load = ((state == ST_VERIFY) && (idx == LAST)) ||
                     ((state == ST_ALT) && pace_expire && !alt_final);

  aat_pacer #(.IVL_W(IVL_W)) u_pacer (
    .clk      (clk),
    .rst      (rst),
    .load     (pace_load),
    .interval (interval),
    .expire   (pace_expire)
  );

  aat_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_checker (
    .clk       (clk),
    .rst       (rst),
    .clear     (go),
    .rd_v      (rd_v),
    .rd_addr   (mem_addr),
    .rd_alt    (rd_alt),
    .rdata     (mem_rdata),
    .fail      (fail),
    .fail_addr (fail_addr),
    .fail_alt  (fail_alt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      idx       <= '0;
      side      <= 1'b0;
      mem_addr  <= '0;
      mem_we    <= 1'b0;
      mem_wdata <= '0;
      done      <= 1'b0;
      rd_v      <= 1'b0;
      rd_alt    <= 1'b0;
    end else begin
      rd_v <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            state     <= ST_FILL;
            idx       <= '0;
            mem_addr  <= '0;
            mem_we    <= 1'b1;
            mem_wdata <= '0;
            done      <= 1'b0;
          end
        end
        ST_FILL: begin
          if (idx == LAST) begin
            state     <= ST_VERIFY;
            idx       <= '0;
            mem_addr  <= '0;
            mem_we    <= 1'b0;
            mem_wdata <= '0;
            rd_v      <= 1'b1;
            rd_alt    <= 1'b0;
          end else begin
            idx       <= idx_nxt;
            mem_addr  <= idx_nxt;
            mem_wdata <= {DATA_W{idx_nxt[ADDR_W-1]}};
          end
        end
        ST_VERIFY: begin
          if (idx == LAST) begin
            state    <= ST_ALT;
            idx      <= '0;
            side     <= 1'b0;
            mem_addr <= '0;
            rd_v     <= 1'b1;
            rd_alt   <= 1'b1;
          end else begin
            idx      <= idx_nxt;
            mem_addr <= idx_nxt;
            rd_v     <= 1'b1;
            rd_alt   <= 1'b0;
          end
        end
        ST_ALT: begin
          if (pace_expire) begin
            if (!side) begin
              mem_addr <= {1'b1, idx[HW-1:0]};
              side     <= 1'b1;
              rd_v     <= 1'b1;
              rd_alt   <= 1'b1;
            end else if (alt_final) begin
              state <= ST_DRAIN1;
            end else begin
              idx      <= idx_nxt;
              mem_addr <= {1'b0, half_nxt};
              side     <= 1'b0;
              rd_v     <= 1'b1;
              rd_alt   <= 1'b1;
            end
          end
        end
        ST_DRAIN1: state <= ST_DRAIN2;
        ST_DRAIN2: begin
          done  <= 1'b1;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_FILL_DATA: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (mem_wdata == {DATA_W{mem_addr[ADDR_W-1]}})) // R1
    else $error("fill word does not match half");

  AST_NO_LATE_WRITE: assert property (@(posedge clk) disable iff (rst)
    (state == ST_VERIFY || state == ST_ALT) |-> !mem_we) // R2
    else $error("write during read passes");

  AST_ALT_PAIR: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ALT && $past(state) == ST_ALT && mem_addr != $past(mem_addr)) |->
      (mem_addr[ADDR_W-1] ? (mem_addr[HW-1:0] == $past(mem_addr[HW-1:0]))
                          : (mem_addr[HW-1:0] == HW'($past(mem_addr[HW-1:0]) + 1'b1)))) // R3
    else $error("alternating order broken");

  AST_ALT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ALT && !pace_expire) |=> $stable(mem_addr)) // R4
    else $error("address moved before interval elapsed");

  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> done) // R7
    else $error("done dropped without start");

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (start && state != ST_IDLE && state != ST_FILL) |=> !mem_we) // R8
    else $error("start restarted a running sequence");
endmodule

// File: tb/alt_access_tester_test.sv
`timescale 1ns/1ps
module alt_access_tester_test;
  localparam int AW = 6;
  localparam int DW = 8;
  localparam int IW = 4;
  localparam int N  = 1 << AW;
  localparam int H  = N / 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [IW-1:0] interval = '0;
  logic [AW-1:0] mem_addr;
  logic          mem_we;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_rdata;
  logic          done;
  logic          fail;
  logic [AW-1:0] fail_addr;
  logic          fail_alt;

  int n_checks = 0;
  int n_fail   = 0;

  // fault model controls
  int flt_mode = 0;  // 0 none, 1 stuck at one address, 2 same but from alt pass, 3 all reads when interval too short
  bit flt_en   = 1'b0;
  int flt_addr = 0;
  int flt_mask = 0;
  int slow_lim = 0;

  logic [DW-1:0] ram [N];

  always #10 clk = ~clk;

  alt_access_tester #(.ADDR_W(AW), .DATA_W(DW), .IVL_W(IW)) uut (
    .clk(clk), .rst(rst), .start(start), .interval(interval),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .done(done), .fail(fail), .fail_addr(fail_addr), .fail_alt(fail_alt)
  );

  function automatic int eff_ivl(int i);
    return (i == 0) ? 1 : i;
  endfunction

  function automatic logic [DW-1:0] corrupt(int a);
    if (!flt_en) return '0;
    if ((flt_mode == 1 || flt_mode == 2) && a == flt_addr) return DW'(flt_mask);
    if (flt_mode == 3 && eff_ivl(int'(interval)) < slow_lim) return '1;
    return '0;
  endfunction

  always_ff @(posedge clk) begin
    if (mem_we) ram[mem_addr] <= mem_wdata;
    mem_rdata <= ram[mem_addr] ^ corrupt(int'(mem_addr));
  end

  function automatic int exp_addr(int j, int iv);
    int r, slot;
    if (j < N) return j;
    if (j < 2 * N) return j - N;
    r = j - 2 * N;
    slot = r / iv;
    return (slot / 2) + (slot % 2) * H;
  endfunction

  function automatic int exp_word(int a);
    return (a >= H) ? (1 << DW) - 1 : 0;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic run(int ivl, int mode, int faddr, int fmask, int slim, bit midstart, output bit failed);
    int iv, dcyc, last_acc;
    int e1, e2, e3, e4, e7;
    int a1, x1, a2, x2, a3, x3, a4, x4;
    bit exp_fail;
    int exp_fa, exp_ph;
    iv = eff_ivl(ivl);
    last_acc = 2 * N + N * iv;
    dcyc = last_acc + 2;
    e1 = 0; e2 = 0; e3 = 0; e4 = 0; e7 = 0;
    a1 = 0; x1 = 0; a2 = 0; x2 = 0; a3 = 0; x3 = 0; a4 = 0; x4 = 0;
    @(negedge clk);
    interval = IW'(ivl);
    flt_mode = mode; flt_addr = faddr; flt_mask = fmask; slow_lim = slim;
    flt_en = (mode == 1);
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    check(fail == 1'b0 && done == 1'b0, "R7", "flags cleared at start", {30'd0, fail, done}, 0);
    for (int j = 0; j <= dcyc; j++) begin
      if (j > 0) @(negedge clk);
      if (j == 2 * N && mode >= 2) flt_en = 1'b1;
      if (midstart && j == 2 * N + 3) start = 1'b1;
      if (midstart && j == 2 * N + 4) start = 1'b0;
      if (j < N) begin
        if (!(mem_we && int'(mem_addr) == j && int'(mem_wdata) == exp_word(j))) begin
          if (e1 == 0) begin a1 = int'(mem_addr); x1 = j; end
          e1++;
        end
      end else if (j < 2 * N) begin
        if (mem_we || int'(mem_addr) != exp_addr(j, iv)) begin
          if (e2 == 0) begin a2 = int'(mem_addr); x2 = exp_addr(j, iv); end
          e2++;
        end
      end else if (j < last_acc) begin
        if (mem_we || int'(mem_addr) != exp_addr(j, iv)) begin
          if (((j - 2 * N) % iv) == 0) begin
            if (e3 == 0) begin a3 = int'(mem_addr); x3 = exp_addr(j, iv); end
            e3++;
          end else begin
            if (e4 == 0) begin a4 = int'(mem_addr); x4 = exp_addr(j, iv); end
            e4++;
          end
        end
      end
      if (j < dcyc && done) e7++;
    end
    check(e1 == 0, "R1", "fill address/data", a1, x1);
    check(e2 == 0, "R2", "verify read order", a2, x2);
    check(e3 == 0, "R3", "alternating order", a3, x3);
    check(e4 == 0, "R4", "alternating hold", a4, x4);
    check(e7 == 0, "R7", "done early cycles", e7, 0);
    check(done == 1'b1, "R7", "done at due cycle", int'(done), 1);
    if (midstart)
      check(e1 + e2 + e3 + e4 + e7 == 0 && done, "R8", "start during run", e1 + e2 + e3 + e4 + e7, 0);
    case (mode)
      1: begin exp_fail = 1'b1; exp_fa = faddr; exp_ph = 0; end
      2: begin exp_fail = 1'b1; exp_fa = faddr; exp_ph = 1; end
      3: begin exp_fail = (iv < slim); exp_fa = 0; exp_ph = 1; end
      default: begin exp_fail = 1'b0; exp_fa = 0; exp_ph = 0; end
    endcase
    check(fail == exp_fail, "R5", "fail flag", int'(fail), int'(exp_fail));
    if (exp_fail) begin
      check(int'(fail_addr) == exp_fa, "R6", "first failing address", int'(fail_addr), exp_fa);
      check(int'(fail_alt) == exp_ph, "R6", "failing pass", int'(fail_alt), exp_ph);
    end
    failed = fail;
    @(negedge clk);
    check(done == 1'b1 && fail == exp_fail && !mem_we, "R7", "flags held after run",
          {30'd0, done, fail}, {30'd0, 1'b1, exp_fail});
    flt_en = 1'b0;
    flt_mode = 0;
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL R7 watchdog: actual still running expected done");
    $display("%0d/%0d checks passed", n_checks + 1 - n_fail, n_checks + 1);
    $finish;
  end

  initial begin
    bit f;
    int best;
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R9 reset state
    check(done == 1'b0 && fail == 1'b0, "R9", "flags after reset", {30'd0, done, fail}, 0);
    check(mem_we == 1'b0 && mem_addr == '0, "R9", "memory port after reset", {25'd0, mem_we, mem_addr}, 0);

    run(1, 0, 0, 0, 0, 1'b0, f);                       // clean, fastest spacing
    run(0, 0, 0, 0, 0, 1'b0, f);                       // R4: zero acts as one
    run(3, 1, 5, 8'h10, 0, 1'b0, f);                   // R6: verify-pass fault, later alt hits ignored
    run(2, 0, 0, 0, 0, 1'b0, f);                       // R7: fail cleared by next start
    run(2, 2, H + 7, 8'h01, 0, 1'b0, f);               // alt-only fault in upper half
    run(4, 0, 0, 0, 0, 1'b1, f);                       // R8: start pulse mid-run

    for (int k = 0; k < 4; k++) begin
      int ri, rm, ra, rk;
      ri = int'($urandom_range(5, 0));
      rm = int'($urandom_range(2, 0));
      ra = int'($urandom_range(N - 1, 0));
      rk = int'($urandom_range(255, 1));
      run(ri, rm, ra, rk, 0, 1'b0, f);
    end

    // interval sweep against a RAM that needs at least 3 cycles between reads (R5)
    best = 0;
    for (int iv = 5; iv >= 1; iv--) begin
      run(iv, 3, 0, 0, 3, 1'b0, f);
      if (!f) best = iv;
    end
    check(best == 3, "R5", "smallest passing interval", best, 3);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule